// File: doc/BRIEF.md
# Banked Internal Data RAM

This block is the 128-byte on-chip scratch memory of a small 8-bit controller core. The core reaches the same byte array in four ways. It can name a byte directly by address. It can name one of eight working registers, which is resolved through the currently active register bank. It can set, clear or test a single bit inside a bit-addressable window. It can push and pop through an internal 8-bit stack pointer. Byte reads and bit reads come back through registered outputs one clock after the request. Writes take effect at the same clock edge.

The bank number is supplied by the core. The core takes it from bits 4:3 of its status word, and that word resets to zero, which selects bank 0. The block keeps no copy of the status word. Any access whose byte target lies at 80h or above belongs to the special-function space and not to this array. Such an access is refused and raises a one-cycle out-of-range flag.

Top module: `bank_iram`

## Requirements
- R1: One cycle after reset is released: `sp` = 07h, `rdata` = 00h, `bit_val` = 0, `oor` = 0, and every byte 00h-7Fh reads back as 00h.
- R2: A direct write stores `wdata` at `dir_addr` (00h-7Fh). A direct read presents the byte on `rdata` one cycle later. `rdata` holds its value in every cycle with no byte read selected.
- R3: Register access with index i (0-7) targets byte 8*b + i, where b is the 2-bit `bank_sel`. Bank 0 covers 00h-07h, bank 1 covers 08h-0Fh, bank 2 covers 10h-17h and bank 3 covers 18h-1Fh.
- R4: A direct read or write with `dir_addr` >= 80h raises `oor` in the next cycle, changes no byte (there is no aliasing onto 00h-7Fh), and a read returns 00h. `oor` is 0 after any cycle with no direct or stack strobe.
- R5: Bit address b (0-127) selects byte 20h + b[6:3] and bit position b[2:0] (0 is the LSB). `bit_rd` presents that bit on `bit_val` one cycle later, and `bit_val` holds otherwise.
- R6: `bit_set` and `bit_clr` change only the addressed bit of its byte, in a single cycle.
- R7: A push adds one to `sp` and then writes `wdata` at the new `sp`. A pop reads the byte at `sp` and then subtracts one. `sp` wraps modulo 256 in both directions.
- R8: A push or pop whose target byte is >= 80h raises `oor`, writes nothing and reads 00h, while `sp` still moves.
- R9: When a write and a byte read, or a bit write and a bit read, fall in the same cycle, the read returns the contents from before the write.
- R10: At most one write happens per cycle, chosen in the order push, register write, direct write, bit set, bit clear. At most one byte read happens, chosen in the order pop, register read, direct read.
- R11: `push` and `pop` in the same cycle act as a push alone: `sp` rises by one, the byte is written, and `rdata` is not updated by the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_sel | input | 2 | Active register bank (status word bits 4:3) |
| dir_rd | input | 1 | Direct byte read strobe |
| dir_wr | input | 1 | Direct byte write strobe |
| dir_addr | input | 8 | Direct byte address |
| reg_rd | input | 1 | Working register read strobe |
| reg_wr | input | 1 | Working register write strobe |
| reg_idx | input | 3 | Working register index |
| bit_rd | input | 1 | Single-bit read strobe |
| bit_set | input | 1 | Single-bit set strobe |
| bit_clr | input | 1 | Single-bit clear strobe |
| bit_addr | input | 7 | Bit address in the bit window |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| wdata | input | 8 | Write data for byte writes and pushes |
| rdata | output | 8 | Registered byte read result |
| bit_val | output | 1 | Registered bit read result |
| oor | output | 1 | Out-of-range access seen in the previous cycle |
| sp | output | 8 | Stack pointer |

## Verification
The case of interest is a write and a read of the same location in one cycle. Examples are a direct write and a direct read of 40h, a bit set on a bit of 21h together with a direct read of 21h, and a bit set together with a bit read of the same bit. The bench raises both strobes on the same falling edge and expects the read to return the old contents. A following read must then show the new value. Conflicting writes are handled in the same way: a register write paired with a direct write, and a set paired with a clear of one bit. A later read must show that only the higher-priority write happened.

// File: rtl/iram_pkg.sv
`timescale 1ns/1ps
// Shared types of the banked internal data RAM.
package iram_pkg;
    // Kind of write applied to the array in one cycle.
    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_BYTE = 2'd1,
        WR_BSET = 2'd2,
        WR_BCLR = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/iram_sp.sv
`timescale 1ns/1ps
// Stack pointer register.
// Holds the pointer, offers the pre-incremented push target and steps on
// push or pop. A push wins when both strobes are high. Wraps modulo 2**W.
module iram_sp #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = 8'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    output logic [W-1:0] sp,
    output logic [W-1:0] push_tgt
);
    // Target of a push: the byte above the current top.
    assign push_tgt = sp + 1'b1;

    // Pointer update: push first, otherwise pop.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= RST_VAL;
        else if (push) sp <= push_tgt;
        else if (pop)  sp <= sp - 1'b1;
    end
endmodule

// File: rtl/iram_sel.sv
`timescale 1ns/1ps
// Access selector.
// Resolves the bank-relative register address, the bit-window byte and the
// stack targets. Picks one write and one byte read by fixed priority and
// reports whether any requested target falls outside the array.
// Assumes the array covers 0 .. 2**AW-1 of a DW-bit address space.
module iram_sel
    import iram_pkg::*;
#(
    parameter int DW       = 8,
    parameter int AW       = 7,
    parameter int IDX_W    = 3,
    parameter int BANK_W   = 2,
    parameter int BIT_BASE = 32,
    parameter int BIT_AW   = 7,
    parameter int PW       = 3
) (
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              dir_rd,
    input  logic              dir_wr,
    input  logic [DW-1:0]     dir_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              bit_set,
    input  logic              bit_clr,
    input  logic [BIT_AW-1:0] bit_addr,
    input  logic              push,
    input  logic              pop,
    input  logic [DW-1:0]     sp,
    input  logic [DW-1:0]     push_tgt,
    output wr_kind_e          wr_kind,
    output logic [AW-1:0]     wr_addr,
    output logic              rd_en,
    output logic              rd_hit,
    output logic [AW-1:0]     rd_addr,
    output logic [AW-1:0]     bit_byte,
    output logic [PW-1:0]     bit_pos,
    output logic              flag
);
    logic [DW-1:0] reg_tgt;
    logic [DW-1:0] wtgt;
    logic [DW-1:0] rtgt;
    wr_kind_e      wsel;
    logic          pop_eff;

    // True when a full-width address lands inside the array.
    function automatic logic in_ram(input logic [DW-1:0] a);
        return (a >> AW) == '0;
    endfunction

    // Register address: the bank number forms the upper bits above the index.
    assign reg_tgt  = DW'({bank_sel, reg_idx});
    // Bit window: byte offset from the upper bit-address bits, position from the low ones.
    assign bit_byte = AW'(BIT_BASE) + AW'(bit_addr >> PW);
    assign bit_pos  = bit_addr[PW-1:0];
    // A pop that meets a push is dropped.
    assign pop_eff  = pop & ~push;

    // Write arbitration: push, register, direct, bit set, bit clear.
    always_comb begin
        wtgt = '0;
        wsel = WR_NONE;
        if (push) begin
            wtgt = push_tgt;
            wsel = WR_BYTE;
        end else if (reg_wr) begin
            wtgt = reg_tgt;
            wsel = WR_BYTE;
        end else if (dir_wr) begin
            wtgt = dir_addr;
            wsel = WR_BYTE;
        end else if (bit_set) begin
            wtgt = DW'(bit_byte);
            wsel = WR_BSET;
        end else if (bit_clr) begin
            wtgt = DW'(bit_byte);
            wsel = WR_BCLR;
        end
        wr_kind = in_ram(wtgt) ? wsel : WR_NONE;
        wr_addr = wtgt[AW-1:0];
    end

    // Byte read arbitration: pop, register, direct.
    always_comb begin
        rtgt  = '0;
        rd_en = 1'b1;
        if (pop_eff)     rtgt = sp;
        else if (reg_rd) rtgt = reg_tgt;
        else if (dir_rd) rtgt = dir_addr;
        else             rd_en = 1'b0;
        rd_hit  = in_ram(rtgt);
        rd_addr = rtgt[AW-1:0];
    end

    // Out-of-range report for any requested direct or stack target.
    assign flag = ((dir_rd | dir_wr) & ~in_ram(dir_addr))
                | (push & ~in_ram(push_tgt))
                | (pop_eff & ~in_ram(sp));
endmodule

// File: rtl/iram_array.sv
`timescale 1ns/1ps
// Byte array with one write port and two registered read ports.
// The write port stores a whole byte or sets or clears one bit by
// read-modify-write in the same cycle. The reads sample contents from before
// that edge's write. An out-of-range byte read returns zero.
module iram_array
    import iram_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 128,
    parameter int AW    = 7,
    parameter int PW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wr_kind_e      wr_kind,
    input  logic [AW-1:0] wr_addr,
    input  logic [PW-1:0] wr_pos,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en,
    input  logic          rd_hit,
    input  logic [AW-1:0] rd_addr,
    input  logic          bit_rd,
    input  logic [AW-1:0] bit_byte,
    output logic [DW-1:0] rdata,
    output logic          bit_val
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] merged;
    logic [DW-1:0] mask;

    // One-hot mask of the bit touched by a bit write.
    assign mask = DW'(1) << wr_pos;

    // New byte value for the selected write kind.
    always_comb begin
        case (wr_kind)
            WR_BYTE: merged = wdata;
            WR_BSET: merged = mem[wr_addr] | mask;
            WR_BCLR: merged = mem[wr_addr] & ~mask;
            default: merged = mem[wr_addr];
        endcase
    end

    // Storage: cleared on reset, one byte updated per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_kind != WR_NONE) begin
            mem[wr_addr] <= merged;
        end
    end

    // Byte read register: loads only when a read is selected.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_hit ? mem[rd_addr] : '0;
    end

    // Bit read register: loads only on a bit read.
    always_ff @(posedge clk) begin
        if (!rst_n)      bit_val <= 1'b0;
        else if (bit_rd) bit_val <= mem[bit_byte][wr_pos];
    end
endmodule

// File: rtl/bank_iram.sv
`timescale 1ns/1ps
// Banked internal data RAM, top level.
// Joins the stack pointer, the access selector and the byte array, and
// registers the out-of-range flag. Assumes the core supplies the bank field
// of its status word and raises at most the strobes it needs in a cycle.
// Simultaneous strobes are resolved by fixed priority.
module bank_iram
    import iram_pkg::*;
#(
    parameter int DW        = 8,
    parameter int DEPTH     = 128,
    parameter int NBANKS    = 4,
    parameter int BANK_REGS = 8,
    parameter int BIT_BASE  = 32,
    parameter int BIT_BYTES = 16,
    parameter int SP_RST    = 7,
    localparam int AW       = $clog2(DEPTH),
    localparam int IDX_W    = $clog2(BANK_REGS),
    localparam int BANK_W   = $clog2(NBANKS),
    localparam int BIT_AW   = $clog2(BIT_BYTES * DW),
    localparam int PW       = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              dir_rd,
    input  logic              dir_wr,
    input  logic [DW-1:0]     dir_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              bit_rd,
    input  logic              bit_set,
    input  logic              bit_clr,
    input  logic [BIT_AW-1:0] bit_addr,
    input  logic              push,
    input  logic              pop,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              bit_val,
    output logic              oor,
    output logic [DW-1:0]     sp
);
    logic [DW-1:0] push_tgt;
    wr_kind_e      wr_kind;
    logic [AW-1:0] wr_addr;
    logic          rd_en;
    logic          rd_hit;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] bit_byte;
    logic [PW-1:0] bit_pos;
    logic          flag;

    iram_sp #(
        .W       (DW),
        .RST_VAL (DW'(SP_RST))
    ) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .sp       (sp),
        .push_tgt (push_tgt)
    );

    iram_sel #(
        .DW       (DW),
        .AW       (AW),
        .IDX_W    (IDX_W),
        .BANK_W   (BANK_W),
        .BIT_BASE (BIT_BASE),
        .BIT_AW   (BIT_AW),
        .PW       (PW)
    ) u_sel (
        .bank_sel (bank_sel),
        .dir_rd   (dir_rd),
        .dir_wr   (dir_wr),
        .dir_addr (dir_addr),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_idx  (reg_idx),
        .bit_set  (bit_set),
        .bit_clr  (bit_clr),
        .bit_addr (bit_addr),
        .push     (push),
        .pop      (pop),
        .sp       (sp),
        .push_tgt (push_tgt),
        .wr_kind  (wr_kind),
        .wr_addr  (wr_addr),
        .rd_en    (rd_en),
        .rd_hit   (rd_hit),
        .rd_addr  (rd_addr),
        .bit_byte (bit_byte),
        .bit_pos  (bit_pos),
        .flag     (flag)
    );

    iram_array #(
        .DW    (DW),
        .DEPTH (DEPTH),
        .AW    (AW),
        .PW    (PW)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_kind  (wr_kind),
        .wr_addr  (wr_addr),
        .wr_pos   (bit_pos),
        .wdata    (wdata),
        .rd_en    (rd_en),
        .rd_hit   (rd_hit),
        .rd_addr  (rd_addr),
        .bit_rd   (bit_rd),
        .bit_byte (bit_byte),
        .rdata    (rdata),
        .bit_val  (bit_val)
    );

    // Out-of-range flag: a one-cycle echo of this cycle's report.
    always_ff @(posedge clk) begin
        if (!rst_n) oor <= 1'b0;
        else        oor <= flag;
    end
endmodule

// File: rtl/bank_iram_chk.sv
`timescale 1ns/1ps
// Checker for bank_iram: pointer stepping, flag timing and output holding.
// Attached to every bank_iram instance by the bind below.
module bank_iram_chk #(
    parameter int DW    = 8,
    parameter int DEPTH = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dir_rd,
    input logic          dir_wr,
    input logic [DW-1:0] dir_addr,
    input logic          reg_rd,
    input logic          bit_rd,
    input logic          push,
    input logic          pop,
    input logic [DW-1:0] rdata,
    input logic          bit_val,
    input logic          oor,
    input logic [DW-1:0] sp
);
    assert_sp_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> sp == $past(sp) + 1'b1);

    assert_sp_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> sp == $past(sp) - 1'b1);

    assert_sp_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(sp));

    assert_oor_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_rd || dir_wr) && int'(dir_addr) >= DEPTH) |=> oor);

    assert_oor_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dir_rd || dir_wr || push || pop) |=> !oor);

    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(dir_rd || reg_rd || pop) |=> $stable(rdata));

    assert_bit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_rd |=> $stable(bit_val));

    assert_pushpop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !reg_rd && !dir_rd) |=> $stable(rdata));
endmodule

bind bank_iram bank_iram_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_bank_iram.sv
`timescale 1ns/1ps
// Scoreboard bench for bank_iram: the driver applies one operation per cycle
// and queues the expected outputs; the monitor compares them after the edge.
module test_bank_iram;
    localparam int DEPTH    = 128;
    localparam int BIT_BASE = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_sel = '0;
    logic       dir_rd = 0, dir_wr = 0, reg_rd = 0, reg_wr = 0;
    logic       bit_rd = 0, bit_set = 0, bit_clr = 0, push = 0, pop = 0;
    logic [7:0] dir_addr = '0, wdata = '0;
    logic [2:0] reg_idx = '0;
    logic [6:0] bit_addr = '0;
    logic [7:0] rdata, sp;
    logic       bit_val, oor;

    always #4 clk = ~clk;

    bank_iram i_bank_iram (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .dir_rd(dir_rd), .dir_wr(dir_wr), .dir_addr(dir_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .bit_rd(bit_rd), .bit_set(bit_set), .bit_clr(bit_clr), .bit_addr(bit_addr),
        .push(push), .pop(pop), .wdata(wdata),
        .rdata(rdata), .bit_val(bit_val), .oor(oor), .sp(sp)
    );

    typedef struct {
        int         due;
        int         kind;   // 0 rdata, 1 bit_val, 2 oor, 3 sp
        logic [7:0] val;
        string      req;
    } exp_t;

    typedef struct {
        logic       dr, dw, rr, rw, bs, bc, br, pu, po;
        logic [7:0] da, wd;
        logic [2:0] ri;
        logic [1:0] bank;
        logic [6:0] ba;
    } op_t;

    exp_t       exp_q[$];
    int         n_chk = 0, n_bad = 0, cyc = 0;
    logic [7:0] ref_mem [DEPTH];
    logic [7:0] ref_sp = 8'h07, ref_rd = 8'h00;
    logic       ref_bit = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, got, exp);
        end
    endtask

    // Monitor: compares queued expectations 2 ns after each rising edge.
    always @(posedge clk) begin
        exp_t e;
        cyc = cyc + 1;
        #2;
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            e = exp_q.pop_front();
            case (e.kind)
                0: check(e.req, "rdata", rdata, e.val);
                1: check(e.req, "bit_val", {7'b0, bit_val}, e.val);
                2: check(e.req, "oor", {7'b0, oor}, e.val);
                default: check(e.req, "sp", sp, e.val);
            endcase
        end
    end

    function automatic op_t nop();
        op_t o;
        o = '{default: '0};
        return o;
    endfunction

    // Driver: applies one operation for one cycle and queues the expected
    // outputs, computed from the requirements on a bench-side model.
    task automatic drive(input op_t o, input string req);
        logic [7:0] rt, wt, nv, up;
        logic       rsel, wk, flag, pop_e;
        @(negedge clk);
        dir_rd = o.dr; dir_wr = o.dw; reg_rd = o.rr; reg_wr = o.rw;
        bit_rd = o.br; bit_set = o.bs; bit_clr = o.bc; push = o.pu; pop = o.po;
        dir_addr = o.da; wdata = o.wd; reg_idx = o.ri; bank_sel = o.bank; bit_addr = o.ba;
        pop_e = o.po && !o.pu;
        up    = ref_sp + 8'd1;
        rsel  = 1'b1;
        rt    = 8'h00;
        if (pop_e)     rt = ref_sp;
        else if (o.rr) rt = {3'b000, o.bank, o.ri};
        else if (o.dr) rt = o.da;
        else           rsel = 1'b0;
        if (rsel) ref_rd = (rt < 8'h80) ? ref_mem[rt[6:0]] : 8'h00;
        if (o.br) ref_bit = ref_mem[BIT_BASE + int'(o.ba[6:3])][o.ba[2:0]];
        flag = ((o.dr || o.dw) && o.da >= 8'h80) || (o.pu && up >= 8'h80)
               || (pop_e && ref_sp >= 8'h80);
        wk = 1'b1;
        wt = 8'h00;
        nv = o.wd;
        if (o.pu)      wt = up;
        else if (o.rw) wt = {3'b000, o.bank, o.ri};
        else if (o.dw) wt = o.da;
        else if (o.bs || o.bc) begin
            wt = 8'(BIT_BASE + int'(o.ba[6:3]));
            nv = ref_mem[wt[6:0]];
            nv[o.ba[2:0]] = o.bs;
        end else wk = 1'b0;
        if (wk && wt < 8'h80) ref_mem[wt[6:0]] = nv;
        if (o.pu)      ref_sp = up;
        else if (o.po) ref_sp = ref_sp - 8'd1;
        exp_q.push_back('{cyc + 1, 0, ref_rd, rsel ? req : "R2"});
        exp_q.push_back('{cyc + 1, 1, {7'b0, ref_bit}, o.br ? req : "R5"});
        exp_q.push_back('{cyc + 1, 2, {7'b0, flag}, flag ? req : "R4"});
        exp_q.push_back('{cyc + 1, 3, ref_sp, (o.pu || o.po) ? req : "R7"});
    endtask

    task automatic idle();
        drive(nop(), "R2");
    endtask
    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
        op_t o = nop(); o.dw = 1; o.da = a; o.wd = d; drive(o, req);
    endtask
    task automatic rd(input logic [7:0] a, input string req);
        op_t o = nop(); o.dr = 1; o.da = a; drive(o, req);
    endtask
    task automatic rwr(input logic [1:0] b, input logic [2:0] i, input logic [7:0] d, input string req);
        op_t o = nop(); o.rw = 1; o.bank = b; o.ri = i; o.wd = d; drive(o, req);
    endtask
    task automatic rrd(input logic [1:0] b, input logic [2:0] i, input string req);
        op_t o = nop(); o.rr = 1; o.bank = b; o.ri = i; drive(o, req);
    endtask
    task automatic bop(input logic s, input logic c, input logic r, input logic [6:0] b, input string req);
        op_t o = nop(); o.bs = s; o.bc = c; o.br = r; o.ba = b; drive(o, req);
    endtask
    task automatic psh(input logic [7:0] d, input string req);
        op_t o = nop(); o.pu = 1; o.wd = d; drive(o, req);
    endtask
    task automatic pp(input string req);
        op_t o = nop(); o.po = 1; drive(o, req);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        op_t o;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        // R1: reset values at the ports
        check("R1", "sp", sp, 8'h07);
        check("R1", "rdata", rdata, 8'h00);
        check("R1", "bit_val", {7'b0, bit_val}, 8'h00);
        check("R1", "oor", {7'b0, oor}, 8'h00);
        for (int a = 0; a < DEPTH; a++) rd(8'(a), "R1");

        // R2: direct writes and reads, with holding in idle cycles
        wr(8'h00, 8'hA1, "R2"); wr(8'h7F, 8'hB2, "R2"); wr(8'h30, 8'hC3, "R2");
        rd(8'h00, "R2"); rd(8'h7F, "R2"); idle(); idle(); rd(8'h30, "R2");

        // R3: every register of every bank, read back directly and by index
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 8; i++)
                rwr(2'(b), 3'(i), 8'(8'h40 + b * 16 + i), "R3");
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 8; i++)
                rd(8'(b * 8 + i), "R3");
        rrd(2'd2, 3'd5, "R3"); rrd(2'd0, 3'd7, "R3"); rrd(2'd3, 3'd0, "R3");

        // R4: writes at and above 80h are refused and do not alias
        wr(8'h80, 8'hEE, "R4"); wr(8'hFF, 8'hDD, "R4");
        rd(8'h00, "R4"); rd(8'h7F, "R4"); rd(8'h90, "R4"); idle();

        // R5 and R6: bit reads and single-bit changes in the window
        wr(8'h20, 8'h5A, "R5"); wr(8'h2F, 8'h0F, "R5"); wr(8'h25, 8'h00, "R5");
        bop(0, 0, 1, 7'h01, "R5"); bop(0, 0, 1, 7'h02, "R5");
        bop(0, 0, 1, 7'h7B, "R5"); bop(0, 0, 1, 7'h7C, "R5");
        bop(1, 0, 0, 7'h7F, "R6"); bop(0, 1, 0, 7'h01, "R6"); bop(1, 0, 0, 7'h2B, "R6");
        rd(8'h2F, "R6"); rd(8'h20, "R6"); rd(8'h25, "R6"); bop(0, 0, 1, 7'h7F, "R6");

        // R9: same-cycle write and read return the old contents
        wr(8'h40, 8'h11, "R9");
        o = nop(); o.dw = 1; o.dr = 1; o.da = 8'h40; o.wd = 8'h22; drive(o, "R9");
        rd(8'h40, "R9");
        o = nop(); o.bs = 1; o.ba = 7'h08; o.dr = 1; o.da = 8'h21; drive(o, "R9");
        rd(8'h21, "R9");
        o = nop(); o.bs = 1; o.br = 1; o.ba = 7'h09; drive(o, "R9");
        bop(0, 0, 1, 7'h09, "R9");

        // R10: write and read priorities
        wr(8'h50, 8'h44, "R10");
        o = nop(); o.rw = 1; o.bank = 2'd1; o.ri = 3'd2; o.dw = 1; o.da = 8'h50; o.wd = 8'h33;
        drive(o, "R10");
        rd(8'h0A, "R10"); rd(8'h50, "R10");
        o = nop(); o.bs = 1; o.bc = 1; o.ba = 7'h10; drive(o, "R10");
        bop(0, 0, 1, 7'h10, "R10");
        o = nop(); o.dw = 1; o.da = 8'h60; o.wd = 8'h77; o.bc = 1; o.ba = 7'h10; drive(o, "R10");
        bop(0, 0, 1, 7'h10, "R10"); rd(8'h60, "R10");
        o = nop(); o.rr = 1; o.bank = 2'd3; o.ri = 3'd1; o.dr = 1; o.da = 8'h7F; drive(o, "R10");

        // R7: push and pop ordering
        psh(8'hA5, "R7"); psh(8'h5A, "R7"); pp("R7"); pp("R7"); rd(8'h08, "R7");

        // R11: push with pop acts as a push
        o = nop(); o.pu = 1; o.po = 1; o.wd = 8'h9C; drive(o, "R11");
        pp("R11");

        // R7 and R8: climb to FFh, wrap to 00h and back
        while (ref_sp != 8'hFF)
            psh(ref_sp ^ 8'h3C, (ref_sp + 8'd1 >= 8'h80) ? "R8" : "R7");
        psh(8'hE7, "R7");
        pp("R7");
        pp("R8");
        pp("R8");
        repeat (3) idle();
        summary();
        $finish;
    end
endmodule